// File: doc/BRIEF.md
# Register Window Invalid-Mask Manager

This block holds the invalid-window mask of a processor with a parameterised number of register windows (`NWIN`, 2 to 32). When the pipeline reports a window overflow or underflow, the block works out which window must go to memory or come back from it. It raises a spill or fill request toward an external transfer engine and holds that request until the engine signals completion.

On completion it moves the single invalid mark by one position. The rotation wraps at the window count, not at the data word width. The mask can also be written directly. Such a write keeps only the bits that name real windows, and it overrides any rotation that falls in the same cycle.

Window numbering follows the usual convention: a save decrements the current window pointer and a restore increments it, both modulo `NWIN`. The block only issues window indices. It never touches register contents.

Top module: `wim_mgr`

## Requirements
- R1: After reset the mask reads 0, `spill_req_o` and `fill_req_o` are low and `busy_o` is low.
- R2: An overflow accepted while idle raises `spill_req_o` and `busy_o` from the next cycle, with `win_idx_o` = (cwp − 2) mod NWIN.
- R3: An underflow accepted while idle raises `fill_req_o` and `busy_o` from the next cycle, with `win_idx_o` = (cwp + 1) mod NWIN.
- R4: While busy and `done_i` is low, the request, its kind and `win_idx_o` hold unchanged, and at most one of the two requests is ever high.
- R5: `done_i` ending a spill rotates the mask right by one. Bit 0 moves to bit NWIN−1. The request and busy drop in the next cycle.
- R6: `done_i` ending a fill rotates the mask left by one. Bit NWIN−1 moves to bit 0. The request and busy drop in the next cycle.
- R7: Overflow and underflow events arriving while busy, including in the completion cycle, are ignored. When both arrive together while idle, the overflow is taken.
- R8: A mask write loads `wim_wdata_i` bits NWIN−1..0. Bits of `wim_o` at NWIN and above always read 0.
- R9: A mask write in the same cycle as `done_i` wins: the mask takes the written value, no rotation is applied, and the request still completes.
- R10: `done_i` while idle has no effect on the mask or the request outputs.
- R11: Elaboration rejects NWIN outside 2..32 and DATA_W below NWIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cwp_i | input | IW | Current window pointer (IW = clog2(NWIN)) |
| ovf_i | input | 1 | Window overflow event |
| unf_i | input | 1 | Window underflow event |
| wim_we_i | input | 1 | Mask write enable |
| wim_wdata_i | input | DATA_W | Mask write data |
| done_i | input | 1 | Transfer engine completion |
| wim_o | output | DATA_W | Current mask, zero above NWIN |
| win_idx_o | output | IW | Window to spill or fill |
| spill_req_o | output | 1 | Spill request (level) |
| fill_req_o | output | 1 | Fill request (level) |
| busy_o | output | 1 | A transfer is outstanding |

## Verification
Two functions can fall in the same cycle: a software mask write and the completion of an outstanding transfer. Both update the mask. The bench starts a fill, then raises `wim_we_i` together with `done_i` at the same clock edge. It judges the outcome by checking that the mask equals the masked write data, not the rotated old value, and that `busy_o` still drops. A second collision, where an overflow and an underflow arrive in the same cycle, and a new event arriving in a completion cycle are judged the same way: by which request, if any, appears next.

// File: rtl/wim_pkg.sv
package wim_pkg;
   typedef enum logic {
      XFER_SPILL = 1'b0,
      XFER_FILL  = 1'b1
   } xfer_kind_e;
endpackage

// File: rtl/wim_rotator.sv
module wim_rotator #(
   parameter int NWIN = 8
) (
   input  logic [NWIN-1:0] wim_i,
   output logic [NWIN-1:0] ror_o,
   output logic [NWIN-1:0] rol_o
);
   for (genvar g = 0; g < NWIN; g++) begin : g_bit
      localparam int UP = (g + 1) % NWIN;
      localparam int DN = (g + NWIN - 1) % NWIN;
      assign ror_o[g] = wim_i[UP];
      assign rol_o[g] = wim_i[DN];
   end
endmodule

// File: rtl/wim_idx_calc.sv
module wim_idx_calc #(
   parameter int NWIN = 8,
   parameter int IW   = 3
) (
   input  logic [IW-1:0] cwp_i,
   output logic [IW-1:0] spill_idx_o,
   output logic [IW-1:0] fill_idx_o
);
   localparam int SW = IW + 1;
   localparam logic [SW-1:0] N_W    = SW'(NWIN);
   localparam logic [SW-1:0] BACK_2 = SW'(NWIN - 2);

   logic [SW-1:0] s_sum, f_sum;

   always_comb begin
      s_sum = {1'b0, cwp_i} + BACK_2;
      if (s_sum >= N_W) s_sum = s_sum - N_W;
      f_sum = {1'b0, cwp_i} + SW'(1);
      if (f_sum >= N_W) f_sum = '0;
      spill_idx_o = s_sum[IW-1:0];
      fill_idx_o  = f_sum[IW-1:0];
   end
endmodule

// File: rtl/wim_seq.sv
module wim_seq
   import wim_pkg::*;
#(
   parameter int NWIN = 8,
   parameter int IW   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ovf_i,
   input  logic            unf_i,
   input  logic            done_i,
   input  logic            we_i,
   input  logic [NWIN-1:0] wdata_i,
   input  logic [IW-1:0]   spill_idx_i,
   input  logic [IW-1:0]   fill_idx_i,
   input  logic [NWIN-1:0] ror_i,
   input  logic [NWIN-1:0] rol_i,
   output logic [NWIN-1:0] wim_o,
   output logic [IW-1:0]   idx_o,
   output logic            busy_o,
   output xfer_kind_e      kind_o
);
   logic [NWIN-1:0] wim_q;
   logic [IW-1:0]   idx_q;
   logic            busy_q;
   xfer_kind_e      kind_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         kind_q <= XFER_SPILL;
         idx_q  <= '0;
      end else if (busy_q) begin
         if (done_i) busy_q <= 1'b0;
      end else if (ovf_i) begin
         busy_q <= 1'b1;
         kind_q <= XFER_SPILL;
         idx_q  <= spill_idx_i;
      end else if (unf_i) begin
         busy_q <= 1'b1;
         kind_q <= XFER_FILL;
         idx_q  <= fill_idx_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                wim_q <= '0;
      else if (we_i)             wim_q <= wdata_i;
      else if (busy_q && done_i) wim_q <= (kind_q == XFER_SPILL) ? ror_i : rol_i;
   end

   assign wim_o  = wim_q;
   assign idx_o  = idx_q;
   assign busy_o = busy_q;
   assign kind_o = kind_q;
endmodule

// File: rtl/wim_mgr.sv
module wim_mgr
   import wim_pkg::*;
#(
   parameter int NWIN   = 8,
   parameter int DATA_W = 32,
   localparam int IW    = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IW-1:0]     cwp_i,
   input  logic              ovf_i,
   input  logic              unf_i,
   input  logic              wim_we_i,
   input  logic [DATA_W-1:0] wim_wdata_i,
   input  logic              done_i,
   output logic [DATA_W-1:0] wim_o,
   output logic [IW-1:0]     win_idx_o,
   output logic              spill_req_o,
   output logic              fill_req_o,
   output logic              busy_o
);
   // R11 parameter checks
   if (NWIN < 2 || NWIN > 32) begin : g_bad_nwin
      $error("wim_mgr: NWIN must lie in 2..32");
   end
   if (DATA_W < NWIN) begin : g_bad_dw
      $error("wim_mgr: DATA_W must be at least NWIN");
   end

   logic [NWIN-1:0] wim_w, ror_w, rol_w;
   logic [IW-1:0]   spill_idx_w, fill_idx_w;
   logic            busy_w;
   xfer_kind_e      kind_w;

   wim_idx_calc #(.NWIN(NWIN), .IW(IW)) u_idx (
      .cwp_i       (cwp_i),
      .spill_idx_o (spill_idx_w),
      .fill_idx_o  (fill_idx_w)
   );

   wim_rotator #(.NWIN(NWIN)) u_rot (
      .wim_i (wim_w),
      .ror_o (ror_w),
      .rol_o (rol_w)
   );

   wim_seq #(.NWIN(NWIN), .IW(IW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ovf_i       (ovf_i),
      .unf_i       (unf_i),
      .done_i      (done_i),
      .we_i        (wim_we_i),
      .wdata_i     (wim_wdata_i[NWIN-1:0]),
      .spill_idx_i (spill_idx_w),
      .fill_idx_i  (fill_idx_w),
      .ror_i       (ror_w),
      .rol_i       (rol_w),
      .wim_o       (wim_w),
      .idx_o       (win_idx_o),
      .busy_o      (busy_w),
      .kind_o      (kind_w)
   );

   assign wim_o       = DATA_W'(wim_w);
   assign busy_o      = busy_w;
   assign spill_req_o = busy_w && (kind_w == XFER_SPILL);
   assign fill_req_o  = busy_w && (kind_w == XFER_FILL);
endmodule

// File: rtl/wim_mgr_chk.sv
module wim_mgr_chk #(
   parameter int NWIN   = 8,
   parameter int DATA_W = 32,
   parameter int IW     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wim_we_i,
   input logic [DATA_W-1:0] wim_wdata_i,
   input logic              done_i,
   input logic [DATA_W-1:0] wim_o,
   input logic [IW-1:0]     win_idx_o,
   input logic              spill_req_o,
   input logic              fill_req_o,
   input logic              busy_o
);
   localparam logic [DATA_W-1:0] MASK = DATA_W'((64'd1 << NWIN) - 64'd1);

   function automatic logic [DATA_W-1:0] rot_r(input logic [DATA_W-1:0] v);
      logic [DATA_W-1:0] r = '0;
      for (int i = 0; i < NWIN; i++) r[i] = v[(i + 1) % NWIN];
      return r;
   endfunction

   function automatic logic [DATA_W-1:0] rot_l(input logic [DATA_W-1:0] v);
      logic [DATA_W-1:0] r = '0;
      for (int i = 0; i < NWIN; i++) r[i] = v[(i + NWIN - 1) % NWIN];
      return r;
   endfunction

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wim_o & ~MASK) == '0); // R8

   AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({spill_req_o, fill_req_o}) && ((spill_req_o || fill_req_o) == busy_o)); // R4

   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !done_i |=> busy_o && $stable(win_idx_o) && $stable(spill_req_o)); // R4

   AST_SPILL_ROT: assert property (@(posedge clk) disable iff (!rst_n)
      spill_req_o && done_i && !wim_we_i |=> wim_o == rot_r($past(wim_o)) && !busy_o); // R5

   AST_FILL_ROT: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req_o && done_i && !wim_we_i |=> wim_o == rot_l($past(wim_o)) && !busy_o); // R6

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wim_we_i |=> wim_o == ($past(wim_wdata_i) & MASK)); // R9

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !wim_we_i |=> $stable(wim_o)); // R10

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(win_idx_o) < NWIN); // R2
endmodule

bind wim_mgr wim_mgr_chk #(.NWIN(NWIN), .DATA_W(DATA_W), .IW(IW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wim_we_i    (wim_we_i),
   .wim_wdata_i (wim_wdata_i),
   .done_i      (done_i),
   .wim_o       (wim_o),
   .win_idx_o   (win_idx_o),
   .spill_req_o (spill_req_o),
   .fill_req_o  (fill_req_o),
   .busy_o      (busy_o)
);

// File: tb/tb_wim_mgr.sv
module tb_wim_mgr;
   localparam int N  = 8;
   localparam int DW = 32;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [IW-1:0] cwp = '0;
   logic ovf = 1'b0, unf = 1'b0, we = 1'b0, done = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] wim;
   logic [IW-1:0] idx;
   logic spill, fill, busy;

   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0] model = '0;
   bit finished = 0;

   always #4 clk = ~clk;

   wim_mgr #(.NWIN(N), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .cwp_i(cwp), .ovf_i(ovf), .unf_i(unf),
      .wim_we_i(we), .wim_wdata_i(wdata), .done_i(done),
      .wim_o(wim), .win_idx_o(idx), .spill_req_o(spill),
      .fill_req_o(fill), .busy_o(busy)
   );

   function automatic logic [DW-1:0] m_ror(input logic [DW-1:0] v);
      return DW'(((v >> 1) | (v << (N - 1))) & ((1 << N) - 1));
   endfunction

   function automatic logic [DW-1:0] m_rol(input logic [DW-1:0] v);
      return DW'(((v << 1) | (v >> (N - 1))) & ((1 << N) - 1));
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // pulse an event at negedge; outputs are sampled one negedge later
   task automatic event_pulse(input logic o, input logic u, input int c);
      cwp = IW'(c); ovf = o; unf = u;
      tick();
      ovf = 0; unf = 0;
   endtask

   task automatic finish_xfer(input logic do_write, input logic [DW-1:0] wd);
      done = 1; we = do_write; wdata = wd;
      tick();
      done = 0; we = 0;
   endtask

   task automatic t_reset();
      check("R1 wim", wim, 0);
      check("R1 spill", DW'(spill), 0);
      check("R1 fill", DW'(fill), 0);
      check("R1 busy", DW'(busy), 0);
   endtask

   task automatic t_write_mask();
      we = 1; wdata = 32'hFFFF_FF01;
      tick(); we = 0;
      model = 32'h01;
      check("R8 masked write", wim, model);
   endtask

   task automatic t_spill_basic();
      event_pulse(1, 0, 5);
      check("R2 spill_req", DW'(spill), 1);
      check("R2 idx", DW'(idx), 3);
      check("R4 fill low", DW'(fill), 0);
      cwp = 0;
      for (int i = 0; i < 3; i++) tick();
      check("R4 busy held", DW'(busy), 1);
      check("R4 idx held", DW'(idx), 3);
      finish_xfer(0, 0);
      model = m_ror(model);
      check("R5 ror wrap", wim, model);
      check("R5 busy drop", DW'(busy), 0);
   endtask

   task automatic t_spill_wrap();
      event_pulse(1, 0, 1);
      check("R2 idx wrap", DW'(idx), 7);
      finish_xfer(0, 0);
      model = m_ror(model);
      check("R5 ror", wim, model);
   endtask

   task automatic t_fill();
      event_pulse(0, 1, 7);
      check("R3 fill_req", DW'(fill), 1);
      check("R3 idx wrap", DW'(idx), 0);
      finish_xfer(0, 0);
      model = m_rol(model);
      check("R6 rol", wim, model);
      event_pulse(0, 1, 2);
      check("R3 idx", DW'(idx), 3);
      finish_xfer(0, 0);
      model = m_rol(model);
      check("R6 rol wrap", wim, model);
      check("R6 fill drop", DW'(fill), 0);
   endtask

   task automatic t_busy_ignore();
      event_pulse(1, 0, 4);
      check("R7 idx", DW'(idx), 2);
      event_pulse(0, 1, 6);
      check("R7 fill ignored", DW'(fill), 0);
      check("R7 idx kept", DW'(idx), 2);
      cwp = 3; ovf = 1;
      finish_xfer(0, 0);
      ovf = 0;
      model = m_ror(model);
      check("R7 event in done cycle", DW'(busy), 0);
      check("R5 rotate", wim, model);
   endtask

   task automatic t_both();
      event_pulse(1, 1, 3);
      check("R7 both spill", DW'(spill), 1);
      check("R7 both no fill", DW'(fill), 0);
      check("R7 both idx", DW'(idx), 1);
      finish_xfer(0, 0);
      model = m_ror(model);
      check("R5 rotate", wim, model);
   endtask

   task automatic t_done_idle();
      done = 1; tick(); done = 0;
      check("R10 wim", wim, model);
      check("R10 no req", DW'({spill, fill, busy}), 0);
   endtask

   task automatic t_write_vs_done();
      event_pulse(0, 1, 0);
      check("R3 idx", DW'(idx), 1);
      finish_xfer(1, 32'hA5A5_012C);
      model = 32'h2C;
      check("R9 write wins", wim, model);
      check("R9 busy drop", DW'(busy), 0);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1;
      tick();
      t_reset();
      t_write_mask();
      t_spill_basic();
      t_spill_wrap();
      t_fill();
      t_busy_ignore();
      t_both();
      t_done_idle();
      t_write_vs_done();
      finished = 1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule